// File: doc/BRIEF.md
# Auxiliary Bit Output Sequencer for Two Audio Channel Pairs

This block sits after the audio de-embedding logic. For each of two channel pairs, A and B, it places the per-frame validity, user and channel-status bits on their own output pins. It also drives a per-pair flag that marks the first frame of each 192-frame channel-status block. Each frame's bits arrive on a one-cycle strobe, together with an indication that the frame opens a channel-status block. The block keeps the most recent bits for each pair. It loads them onto the output pins only in the clock cycle where a rising edge of the audio word clock is detected, so downstream logic sees bits that are aligned to the audio words.

A frame counter for each pair runs modulo 192 and advances once per word-clock rising edge. Any block-start indication seen on that pair forces the counter back to zero. The flag goes high for the frame in which the count is zero. When the output format select chooses the AES/EBU format, all of these pins are unused and are held low. The counters keep running so that block alignment is kept when the format changes back.

Top module: `aux_bit_sequencer`

## Requirements
- R1: Outside the AES/EBU format (`fmt_aes`=0), the pair A outputs carry only bits delivered on the pair A strobe, and the pair B outputs carry only bits delivered on the pair B strobe.
- R2: A word-clock rising edge is a cycle in which `wclk` is sampled high after having been sampled low in the previous cycle. The outputs register, the flag included, changes only at the clock edge where such a rising edge is detected, when the AES/EBU format is entered, or on reset.
- R3: At a word-clock rising edge, a pair loads the bits of its most recent strobe. A strobe in the same cycle as the rising edge is used directly. If no strobe arrived since the previous edge, the previous bits are repeated.
- R4: A pair's frame count advances by one at each word-clock rising edge and wraps from 191 to 0. The flag output is 1 exactly for frames whose count is 0, so without resynchronisation it is high for one frame in 192.
- R5: A strobe with the block-start input at 1, seen since the previous rising edge or in the same cycle as the rising edge, sets that pair's count to 0 at the next rising edge, so the flag is 1 for that frame. The indication is consumed by that edge.
- R6: The flag and the V/U/C bits of a frame are loaded at the same word-clock rising edge.
- R7: While `fmt_aes`=1, all eight outputs are 0 from the next clock edge onward. The frame counters and the held bits keep updating in this format.
- R8: After `fmt_aes` returns to 0, the outputs stay 0 until the next word-clock rising edge loads them.
- R9: While `rst_n`=0 at a clock edge, the counters, held bits and pending block-start indications are cleared and all outputs are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wclk | input | 1 | Audio word clock, synchronous to clk |
| fmt_aes | input | 1 | 1 selects the AES/EBU output format (aux pins held low) |
| pa_frame_stb | input | 1 | Pair A: one-cycle strobe, the frame's bits are valid |
| pa_val | input | 1 | Pair A validity bit |
| pa_usr | input | 1 | Pair A user bit |
| pa_cst | input | 1 | Pair A channel-status bit |
| pa_blk_start | input | 1 | Pair A: this frame opens a channel-status block |
| pb_frame_stb | input | 1 | Pair B: one-cycle strobe, the frame's bits are valid |
| pb_val | input | 1 | Pair B validity bit |
| pb_usr | input | 1 | Pair B user bit |
| pb_cst | input | 1 | Pair B channel-status bit |
| pb_blk_start | input | 1 | Pair B: this frame opens a channel-status block |
| pa_val_o | output | 1 | Pair A validity output |
| pa_usr_o | output | 1 | Pair A user output |
| pa_cst_o | output | 1 | Pair A channel-status output |
| pa_blk_o | output | 1 | Pair A block-start flag |
| pb_val_o | output | 1 | Pair B validity output |
| pb_usr_o | output | 1 | Pair B user output |
| pb_cst_o | output | 1 | Pair B channel-status output |
| pb_blk_o | output | 1 | Pair B block-start flag |

## Verification
The word clock runs at one eighth of the system clock. The two pairs are given independent random bits, and each frame's strobe is placed at random: in the low phase, in the rising-edge cycle itself, or left out entirely. These placements separate the bypass path, the holding path and the repeat path, and crossed pairs show up because the pairs' bits differ. Block-start indications arrive at different frames on the two pairs, which shows that each counter resynchronises on its own. An undisturbed stretch of 192 frames confirms the wrap point. The AES/EBU format is entered and left in the middle of a frame to show that the pins are forced low at once and reload only at a rising edge, while the block alignment runs on underneath.

// File: rtl/aux_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the auxiliary bit output sequencer.
// Assumes: exactly two channel pairs, which matches the top-level port list.
package aux_seq_pkg;
    localparam int NPAIRS = 2;

    // Per-frame auxiliary bits of one pair.
    typedef struct packed {
        logic v;
        logic u;
        logic c;
    } vuc_t;

    // Registered output set of one pair.
    typedef struct packed {
        vuc_t bits;
        logic blk;
    } aux_out_t;
endpackage

// File: rtl/wclk_rise_det.sv
`timescale 1ns/1ps
// Module: wclk_rise_det
// Flags the cycle in which the word clock is sampled high after being
// sampled low. Assumes wclk is already synchronous to clk.
module wclk_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    output logic rise
);
    logic wclk_q;

    // Keep last cycle's word-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
        end else begin
            wclk_q <= wclk;
        end
    end

    assign rise = wclk & ~wclk_q;
endmodule

// File: rtl/aux_hold.sv
`timescale 1ns/1ps
// Module: aux_hold
// Holds the most recent V/U/C bits of one pair and a pending block-start
// indication. It presents the values to use at a word-clock edge, and a
// strobe in the edge cycle bypasses the holding register.
// Assumes: the strobe is one cycle wide per frame.
module aux_hold
    import aux_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  vuc_t bits_in,
    input  logic blk_in,
    input  logic consume,
    output vuc_t bits_use,
    output logic blk_use
);
    vuc_t held_bits;
    logic blk_pend;

    // Capture bits on each strobe and accumulate block-start until consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_bits <= '0;
            blk_pend  <= 1'b0;
        end else begin
            if (stb) begin
                held_bits <= bits_in;
            end
            if (consume) begin
                blk_pend <= 1'b0;
            end else if (stb && blk_in) begin
                blk_pend <= 1'b1;
            end
        end
    end

    // Select the live strobe over the held copy.
    always_comb begin
        bits_use = stb ? bits_in : held_bits;
        blk_use  = blk_pend | (stb & blk_in);
    end
endmodule

// File: rtl/frame_ctr.sv
`timescale 1ns/1ps
// Module: frame_ctr
// Modulo-FRAMES frame counter for one pair. It advances on adv and restarts
// at zero when resync is set together with adv. It reports whether the
// value being loaded is zero.
// Assumes: FRAMES >= 2.
module frame_ctr #(
    parameter int FRAMES = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic resync,
    output logic zero_next
);
    localparam int CW = $clog2(FRAMES);
    localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    // Next count: restart on resync, otherwise wrap at the last frame.
    always_comb begin
        if (resync || cnt == LAST) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt + 1'b1;
        end
    end

    // Load the next count at each word-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt_nxt;
        end
    end

    assign zero_next = (cnt_nxt == '0);
endmodule

// File: rtl/aux_lane.sv
`timescale 1ns/1ps
// Module: aux_lane
// One channel pair: bit holding, frame counting and the output register.
// The output register loads bits and flag together on a word-clock edge
// and is forced low while the AES/EBU format is selected.
module aux_lane
    import aux_seq_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rise,
    input  logic     fmt_aes,
    input  logic     stb,
    input  vuc_t     bits_in,
    input  logic     blk_in,
    output aux_out_t out
);
    vuc_t bits_use;
    logic blk_use;
    logic zero_next;

    aux_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (stb),
        .bits_in  (bits_in),
        .blk_in   (blk_in),
        .consume  (rise),
        .bits_use (bits_use),
        .blk_use  (blk_use)
    );

    frame_ctr #(.FRAMES(FRAMES)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (rise),
        .resync    (blk_use),
        .zero_next (zero_next)
    );

    // Output register: cleared in the AES/EBU format, loaded on edges otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out <= '0;
        end else if (fmt_aes) begin
            out <= '0;
        end else if (rise) begin
            out.bits <= bits_use;
            out.blk  <= zero_next;
        end
    end
endmodule

// File: rtl/aux_bit_sequencer.sv
`timescale 1ns/1ps
// Module: aux_bit_sequencer (top)
// Drives per-pair V/U/C and block-start pins aligned to the word clock for
// two channel pairs. Assumes all inputs are synchronous to clk.
module aux_bit_sequencer
    import aux_seq_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    input  logic fmt_aes,
    input  logic pa_frame_stb,
    input  logic pa_val,
    input  logic pa_usr,
    input  logic pa_cst,
    input  logic pa_blk_start,
    input  logic pb_frame_stb,
    input  logic pb_val,
    input  logic pb_usr,
    input  logic pb_cst,
    input  logic pb_blk_start,
    output logic pa_val_o,
    output logic pa_usr_o,
    output logic pa_cst_o,
    output logic pa_blk_o,
    output logic pb_val_o,
    output logic pb_usr_o,
    output logic pb_cst_o,
    output logic pb_blk_o
);
    logic     rise;
    logic     stb_v [NPAIRS];
    vuc_t     bits_v[NPAIRS];
    logic     blk_v [NPAIRS];
    aux_out_t out_v [NPAIRS];

    wclk_rise_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .wclk  (wclk),
        .rise  (rise)
    );

    // Gather the per-pair input pins into arrays.
    always_comb begin
        stb_v[0]  = pa_frame_stb;
        bits_v[0] = '{v: pa_val, u: pa_usr, c: pa_cst};
        blk_v[0]  = pa_blk_start;
        stb_v[1]  = pb_frame_stb;
        bits_v[1] = '{v: pb_val, u: pb_usr, c: pb_cst};
        blk_v[1]  = pb_blk_start;
    end

    for (genvar p = 0; p < NPAIRS; p++) begin : g_lane
        aux_lane #(.FRAMES(FRAMES)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise),
            .fmt_aes (fmt_aes),
            .stb     (stb_v[p]),
            .bits_in (bits_v[p]),
            .blk_in  (blk_v[p]),
            .out     (out_v[p])
        );
    end

    // Spread the per-pair output sets onto the pins.
    always_comb begin
        pa_val_o = out_v[0].bits.v;
        pa_usr_o = out_v[0].bits.u;
        pa_cst_o = out_v[0].bits.c;
        pa_blk_o = out_v[0].blk;
        pb_val_o = out_v[1].bits.v;
        pb_usr_o = out_v[1].bits.u;
        pb_cst_o = out_v[1].bits.c;
        pb_blk_o = out_v[1].blk;
    end
endmodule

// File: rtl/aux_bit_sequencer_chk.sv
`timescale 1ns/1ps
// Module: aux_bit_sequencer_chk
// Port-level properties of the sequencer. It keeps its own word-clock edge
// detector and its own per-pair record of block-start indications.
module aux_bit_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic wclk,
    input logic fmt_aes,
    input logic pa_frame_stb,
    input logic pa_val,
    input logic pa_usr,
    input logic pa_cst,
    input logic pa_blk_start,
    input logic pb_frame_stb,
    input logic pb_val,
    input logic pb_usr,
    input logic pb_cst,
    input logic pb_blk_start,
    input logic pa_val_o,
    input logic pa_usr_o,
    input logic pa_cst_o,
    input logic pa_blk_o,
    input logic pb_val_o,
    input logic pb_usr_o,
    input logic pb_cst_o,
    input logic pb_blk_o
);
    logic ck_wq;
    logic ck_seen_a;
    logic ck_seen_b;
    logic ck_rise;
    logic [7:0] ck_outs;

    assign ck_rise = wclk & ~ck_wq;
    assign ck_outs = {pa_val_o, pa_usr_o, pa_cst_o, pa_blk_o,
                      pb_val_o, pb_usr_o, pb_cst_o, pb_blk_o};

    // Track the word-clock level and block-start indications seen per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_wq     <= 1'b0;
            ck_seen_a <= 1'b0;
            ck_seen_b <= 1'b0;
        end else begin
            ck_wq     <= wclk;
            ck_seen_a <= ck_rise ? 1'b0 : (ck_seen_a | (pa_frame_stb & pa_blk_start));
            ck_seen_b <= ck_rise ? 1'b0 : (ck_seen_b | (pb_frame_stb & pb_blk_start));
        end
    end

    assert_outs_hold_between_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ck_rise && !fmt_aes) |=> $stable(ck_outs));

    assert_pair_a_routing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_rise && !fmt_aes && pa_frame_stb) |=>
        (pa_val_o == $past(pa_val) && pa_usr_o == $past(pa_usr) && pa_cst_o == $past(pa_cst)));

    assert_pair_b_routing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_rise && !fmt_aes && pb_frame_stb) |=>
        (pb_val_o == $past(pb_val) && pb_usr_o == $past(pb_usr) && pb_cst_o == $past(pb_cst)));

    assert_resync_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_rise && !fmt_aes && (ck_seen_a || (pa_frame_stb && pa_blk_start))) |=> pa_blk_o);

    assert_resync_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_rise && !fmt_aes && (ck_seen_b || (pb_frame_stb && pb_blk_start))) |=> pb_blk_o);

    assert_flag_single_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_rise && !fmt_aes && pa_blk_o && !ck_seen_a && !(pa_frame_stb && pa_blk_start))
        |=> !pa_blk_o);

    assert_aes_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_aes |=> (ck_outs == 8'h00));
endmodule

bind aux_bit_sequencer aux_bit_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wclk         (wclk),
    .fmt_aes      (fmt_aes),
    .pa_frame_stb (pa_frame_stb),
    .pa_val       (pa_val),
    .pa_usr       (pa_usr),
    .pa_cst       (pa_cst),
    .pa_blk_start (pa_blk_start),
    .pb_frame_stb (pb_frame_stb),
    .pb_val       (pb_val),
    .pb_usr       (pb_usr),
    .pb_cst       (pb_cst),
    .pb_blk_start (pb_blk_start),
    .pa_val_o     (pa_val_o),
    .pa_usr_o     (pa_usr_o),
    .pa_cst_o     (pa_cst_o),
    .pa_blk_o     (pa_blk_o),
    .pb_val_o     (pb_val_o),
    .pb_usr_o     (pb_usr_o),
    .pb_cst_o     (pb_cst_o),
    .pb_blk_o     (pb_blk_o)
);

// File: tb/tb_aux_bit_sequencer.sv
`timescale 1ns/1ps
// Bench: drives a word clock of 8 system cycles per frame and compares the
// outputs to a behavioural model on every clock.
module tb_aux_bit_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wclk = 1'b0;
    logic fmt_aes = 1'b0;
    logic stb[2];
    logic iv[2];
    logic iu[2];
    logic ic[2];
    logic ib[2];
    logic [3:0] dut_o[2];
    logic pa_val_o, pa_usr_o, pa_cst_o, pa_blk_o;
    logic pb_val_o, pb_usr_o, pb_cst_o, pb_blk_o;

    int checks = 0;
    int fails = 0;
    string cur_req = "R9";

    // Reference model state.
    int m_cnt[2];
    bit m_hold[2][3];
    bit m_pend[2];
    bit [3:0] m_out[2];
    bit m_wq;

    always #2 clk = ~clk;

    aux_bit_sequencer dut (
        .clk(clk), .rst_n(rst_n), .wclk(wclk), .fmt_aes(fmt_aes),
        .pa_frame_stb(stb[0]), .pa_val(iv[0]), .pa_usr(iu[0]), .pa_cst(ic[0]), .pa_blk_start(ib[0]),
        .pb_frame_stb(stb[1]), .pb_val(iv[1]), .pb_usr(iu[1]), .pb_cst(ic[1]), .pb_blk_start(ib[1]),
        .pa_val_o(pa_val_o), .pa_usr_o(pa_usr_o), .pa_cst_o(pa_cst_o), .pa_blk_o(pa_blk_o),
        .pb_val_o(pb_val_o), .pb_usr_o(pb_usr_o), .pb_cst_o(pb_cst_o), .pb_blk_o(pb_blk_o)
    );

    assign dut_o[0] = {pa_val_o, pa_usr_o, pa_cst_o, pa_blk_o};
    assign dut_o[1] = {pb_val_o, pb_usr_o, pb_cst_o, pb_blk_o};

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Model of one clock edge, written from the requirements.
    task automatic model_step();
        bit rise;
        rise = wclk && !m_wq;
        for (int p = 0; p < 2; p++) begin
            if (!rst_n) begin
                m_cnt[p] = 0; m_pend[p] = 0; m_out[p] = 4'b0;
                m_hold[p][0] = 0; m_hold[p][1] = 0; m_hold[p][2] = 0;
            end else begin
                bit uv, uu, uc, ublk;
                uv = stb[p] ? iv[p] : m_hold[p][0];
                uu = stb[p] ? iu[p] : m_hold[p][1];
                uc = stb[p] ? ic[p] : m_hold[p][2];
                ublk = m_pend[p] || (stb[p] && ib[p]);
                if (rise) begin
                    m_cnt[p] = ublk ? 0 : (m_cnt[p] + 1) % 192;
                    if (!fmt_aes) m_out[p] = {uv, uu, uc, m_cnt[p] == 0};
                    m_pend[p] = 0;
                end else if (stb[p] && ib[p]) begin
                    m_pend[p] = 1;
                end
                if (stb[p]) begin
                    m_hold[p][0] = iv[p]; m_hold[p][1] = iu[p]; m_hold[p][2] = ic[p];
                end
                if (fmt_aes) m_out[p] = 4'b0;
            end
        end
        m_wq = rst_n ? wclk : 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_step();
        for (int p = 0; p < 2; p++) check(cur_req, dut_o[p], m_out[p]);
    endtask

    // One frame: wclk high for 4 cycles then low; pos[p] = strobe cycle or -1.
    task automatic run_frame(input int pos0, input int pos1, input bit blk0, input bit blk1);
        for (int c = 0; c < 8; c++) begin
            wclk = (c < 4);
            for (int p = 0; p < 2; p++) begin
                stb[p] = (c == (p == 0 ? pos0 : pos1));
                iv[p] = 1'($urandom_range(0, 1));
                iu[p] = 1'($urandom_range(0, 1));
                ic[p] = 1'($urandom_range(0, 1));
                ib[p] = p == 0 ? blk0 : blk1;
            end
            tick();
        end
        for (int p = 0; p < 2; p++) stb[p] = 1'b0;
    endtask

    function automatic int pick_pos();
        int r;
        r = $urandom_range(0, 3);
        return r == 0 ? -1 : (r == 1 ? 0 : 4 + r);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int highs;
        for (int p = 0; p < 2; p++) begin
            stb[p] = 0; iv[p] = 1; iu[p] = 1; ic[p] = 1; ib[p] = 1;
        end
        // R9: reset with activity on the inputs.
        cur_req = "R9";
        for (int c = 0; c < 6; c++) begin
            wclk = c[1];
            stb[0] = 1; stb[1] = 1;
            tick();
        end
        check("R9 reset pair A", dut_o[0], 4'b0);
        check("R9 reset pair B", dut_o[1], 4'b0);
        stb[0] = 0; stb[1] = 0; wclk = 0;
        rst_n = 1;
        tick();

        // R1/R2/R3/R6: random bits and strobe placements, staggered resyncs (R5).
        cur_req = "R1/R2/R3/R5/R6";
        for (int f = 0; f < 300; f++) begin
            run_frame(pick_pos(), pick_pos(), f == 5 || f == 250, f == 11 || f == 120);
        end

        // R4/R5: resync pair A, then 192 frames with no block-start.
        cur_req = "R4/R5";
        run_frame(5, 6, 1'b1, 1'b0);
        run_frame(pick_pos(), pick_pos(), 1'b0, 1'b0);
        check("R5 flag after resync", {3'b0, pa_blk_o}, 4'b0001);
        highs = 0;
        for (int f = 2; f <= 192; f++) begin
            run_frame(pick_pos(), pick_pos(), 1'b0, 1'b0);
            if (pa_blk_o) highs++;
        end
        check("R4 flag low for frames 1..191", 4'(highs), 4'd0);
        run_frame(pick_pos(), pick_pos(), 1'b0, 1'b0);
        check("R4 flag after 192 frames", {3'b0, pa_blk_o}, 4'b0001);

        // R7: enter AES format mid-frame; counters keep running.
        cur_req = "R7";
        wclk = 0;
        fmt_aes = 1;
        tick();
        check("R7 pair A low", dut_o[0], 4'b0);
        check("R7 pair B low", dut_o[1], 4'b0);
        for (int f = 0; f < 40; f++) run_frame(pick_pos(), pick_pos(), f == 7, 1'b0);

        // R8: leave AES format in the low phase; stay low until next edge.
        cur_req = "R8";
        wclk = 0;
        stb[0] = 1; iv[0] = 1; iu[0] = 1; ic[0] = 1; ib[0] = 0;
        tick();
        stb[0] = 0;
        fmt_aes = 0;
        tick();
        tick();
        check("R8 pair A still low", dut_o[0], 4'b0);
        check("R8 pair B still low", dut_o[1], 4'b0);
        cur_req = "R4/R7/R8";
        for (int f = 0; f < 200; f++) run_frame(pick_pos(), pick_pos(), 1'b0, f == 50);

        // R9: reset mid-run clears outputs.
        cur_req = "R9";
        rst_n = 0;
        tick();
        check("R9 mid-run reset A", dut_o[0], 4'b0);
        check("R9 mid-run reset B", dut_o[1], 4'b0);
        rst_n = 1;
        cur_req = "R3/R4";
        for (int f = 0; f < 20; f++) run_frame(pick_pos(), pick_pos(), 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule